// File: doc/BRIEF.md
# Token Counting Coherence Controller

This block is the coherence agent of one node for a small group of cache lines. Each line holds a count of tokens out of a fixed total per line, an owner-token flag and a data-valid flag. Read permission follows from holding at least one token with valid data. Write permission follows only from holding every token. Permission never depends on the order in which requests arrive, and no directory is involved.

Local loads and stores that lack permission start a miss. The miss broadcasts a request over an unordered network. Requests from other nodes are answered with tokens, and with data when the owner token is held. Token responses arriving from the network are added to the line. A miss that times out is broadcast again. After four failed attempts the line waits a longer interval, then raises an escalation flag for a separate persistent-request mechanism.

Eviction sends the tokens of a line toward memory, and the data too when the owner token goes with them.

Top module: `tc_ctrl`

## Requirements
- R1: After reset every line holds zero tokens and no valid data. No completion, broadcast, outgoing response, escalation or error is asserted.
- R2: A load completes once the line holds at least one token and valid data. `cpu_done_o[line]` is high in the cycle in which both conditions first hold together with the outstanding miss.
- R3: A store completes only when the line holds all TOK_TOTAL tokens and valid data. With TOK_TOTAL-1 tokens the store stays pending.
- R4: A read request from the network, arriving at a line that holds the owner token and valid data, produces one response. If the line holds two or more tokens, the response carries exactly one non-owner token plus data and the rest stay. If the line holds only the owner token, that token goes out with data and the owner flag set.
- R5: A line without the owner token sends no response to a read request from the network, and its count does not change.
- R6: A write request from the network makes the line send all of its tokens, the owner flag if held, and data if valid. The line is left with zero tokens.
- R7: Incoming tokens add to the count. A response that would push the count above TOK_TOTAL raises `proto_err_o` in that cycle and is discarded whole.
- R8: A load or store without permission raises `bcast_valid_o` in the next cycle, with the line on `bcast_line_o` and `bcast_wr_o` set to 1 for a store and 0 for a load. A request that already has permission broadcasts nothing. Among lines waiting to broadcast, the lowest index goes first.
- R9: A pending miss is broadcast again every 2*AVG_LAT+1 cycles. The extra cycle is the broadcast cycle itself.
- R10: After four broadcasts in total (four failed attempts), the line waits LONG_MULT*2*AVG_LAT further cycles after the last timeout and then raises `escalate_o[line]`. The flag holds until completion. Completion clears the flag and the attempt count, so the next miss again gets four broadcasts.
- R11: Eviction returns every token of the line toward memory (`out_to_mem_o`=1), with data and the owner flag if the owner token is held. An eviction is ignored when a network request arrives in the same cycle, or when the line has a miss outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Local access request |
| cpu_wr_i | input | 1 | 1 = store, 0 = load |
| cpu_line_i | input | LW | Line addressed by the local request |
| cpu_done_o | output | NUM_LINES | Per-line completion |
| bcast_valid_o | output | 1 | Broadcast request valid |
| bcast_wr_o | output | 1 | Broadcast is a write request |
| bcast_line_o | output | LW | Line of the broadcast |
| snp_valid_i | input | 1 | Request from the network |
| snp_wr_i | input | 1 | Network request is a write request |
| snp_line_i | input | LW | Line of the network request |
| rsp_valid_i | input | 1 | Token response from the network |
| rsp_line_i | input | LW | Line of the incoming response |
| rsp_tokens_i | input | CW | Tokens carried in |
| rsp_owner_i | input | 1 | Owner token carried in |
| rsp_data_i | input | 1 | Valid data carried in |
| out_valid_o | output | 1 | Outgoing response valid |
| out_line_o | output | LW | Line of the outgoing response |
| out_tokens_o | output | CW | Tokens sent out |
| out_owner_o | output | 1 | Owner token sent out |
| out_data_o | output | 1 | Data sent out |
| out_to_mem_o | output | 1 | Response is an eviction toward memory |
| evict_i | input | 1 | Evict request |
| evict_line_i | input | LW | Line to evict |
| escalate_o | output | NUM_LINES | Per-line persistent-request escalation |
| proto_err_o | output | 1 | Incoming response would exceed the token total |

## Verification
The hardest situation to reach from the ports is escalation. It needs a miss to fail four times and then sit out the long wait, while no token arrives at all. The bench starts a store miss on an empty line and withholds every response. It measures the spacing of each rebroadcast and the delay from the last broadcast to the escalation flag. After completing the miss, it runs the same starved sequence a second time to show that the attempt count was cleared.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned TC_MAX_TRIES = 4;
  localparam int unsigned TC_FW = $clog2(TC_MAX_TRIES + 1);
endpackage

// File: rtl/tc_pick.sv
module tc_pick #(
  parameter  int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |req_i;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tc_line.sv
module tc_line import tc_pkg::*; #(
  parameter  int unsigned TOK_TOTAL = 16,
  parameter  int unsigned AVG_LAT   = 8,
  parameter  int unsigned LONG_MULT = 4,
  localparam int unsigned CW        = $clog2(TOK_TOTAL + 1),
  localparam int unsigned TO_CYC    = 2 * AVG_LAT,
  localparam int unsigned LONG_CYC  = LONG_MULT * TO_CYC,
  localparam int unsigned TW        = $clog2(LONG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic          snp_i,
  input  logic          snp_wr_i,
  input  logic          evict_i,
  input  logic          rin_i,
  input  logic [CW-1:0] rin_tok_i,
  input  logic          rin_own_i,
  input  logic          rin_dat_i,
  input  logic          grant_i,
  output logic [CW-1:0] out_tok_o,
  output logic          out_own_o,
  output logic          out_dat_o,
  output logic          issue_o,
  output logic          kind_o,
  output logic          done_o,
  output logic          pers_o,
  output logic          ovf_o,
  output logic [CW-1:0] tok_o
);
  logic [CW-1:0]    tok_q, keep, tok_n;
  logic             own_q, val_q, own_n, val_n;
  logic             act_q, wr_q, want_q, pers_q;
  logic [TW-1:0]    tmr_q, lim;
  logic [TC_FW-1:0] fail_q;
  logic [CW:0]      sum;
  logic             have_rd, have_wr, perm, rin_ok;

  assign have_rd = (tok_q != '0) && val_q;
  assign have_wr = (tok_q == CW'(TOK_TOTAL)) && val_q;
  assign perm    = wr_q ? have_wr : have_rd;

  always_comb begin
    out_tok_o = '0;
    out_own_o = 1'b0;
    out_dat_o = 1'b0;
    if (snp_i && snp_wr_i) begin
      out_tok_o = tok_q;
      out_own_o = own_q;
      out_dat_o = val_q;
    end else if (snp_i) begin
      if (own_q && val_q) begin
        out_dat_o = 1'b1;
        if (tok_q > CW'(1)) begin
          out_tok_o = CW'(1);
        end else begin
          out_tok_o = tok_q;
          out_own_o = 1'b1;
        end
      end
    end else if (evict_i && !act_q) begin
      out_tok_o = tok_q;
      out_own_o = own_q;
      out_dat_o = own_q && val_q;
    end
  end

  assign keep   = tok_q - out_tok_o;
  assign sum    = {1'b0, keep} + {1'b0, rin_tok_i};
  assign ovf_o  = rin_i && (sum > (CW+1)'(TOK_TOTAL));
  assign rin_ok = rin_i && !ovf_o;
  assign tok_n  = rin_ok ? sum[CW-1:0] : keep;
  assign own_n  = (own_q && !out_own_o) || (rin_ok && rin_own_i);
  assign val_n  = (tok_n != '0) && ((val_q && keep != '0) || (rin_ok && rin_dat_i));
  assign lim    = (fail_q == TC_FW'(TC_MAX_TRIES)) ? TW'(LONG_CYC - 1) : TW'(TO_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q  <= '0;
      own_q  <= 1'b0;
      val_q  <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      want_q <= 1'b0;
      pers_q <= 1'b0;
      tmr_q  <= '0;
      fail_q <= '0;
    end else begin
      tok_q <= tok_n;
      own_q <= own_n;
      val_q <= val_n;
      if (act_q && perm) begin
        act_q  <= 1'b0;
        want_q <= 1'b0;
        pers_q <= 1'b0;
        tmr_q  <= '0;
        fail_q <= '0;
      end else if (!act_q) begin
        if (req_i) begin
          act_q  <= 1'b1;
          wr_q   <= req_wr_i;
          want_q <= req_wr_i ? !have_wr : !have_rd;
          tmr_q  <= '0;
          fail_q <= '0;
        end
      end else if (want_q) begin
        if (grant_i) want_q <= 1'b0;
      end else if (!pers_q) begin
        if (tmr_q == lim) begin
          tmr_q <= '0;
          if (fail_q == TC_FW'(TC_MAX_TRIES)) begin
            pers_q <= 1'b1;
          end else begin
            fail_q <= fail_q + TC_FW'(1);
            want_q <= (fail_q != TC_FW'(TC_MAX_TRIES - 1));
          end
        end else begin
          tmr_q <= tmr_q + TW'(1);
        end
      end
    end
  end

  assign issue_o = want_q;
  assign kind_o  = wr_q;
  assign done_o  = act_q && perm;
  assign pers_o  = pers_q;
  assign tok_o   = tok_q;
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl #(
  parameter  int unsigned NUM_LINES = 4,
  parameter  int unsigned TOK_TOTAL = 16,
  parameter  int unsigned AVG_LAT   = 8,
  parameter  int unsigned LONG_MULT = 4,
  localparam int unsigned LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned CW        = $clog2(TOK_TOTAL + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_req_i,
  input  logic                 cpu_wr_i,
  input  logic [LW-1:0]        cpu_line_i,
  output logic [NUM_LINES-1:0] cpu_done_o,
  output logic                 bcast_valid_o,
  output logic                 bcast_wr_o,
  output logic [LW-1:0]        bcast_line_o,
  input  logic                 snp_valid_i,
  input  logic                 snp_wr_i,
  input  logic [LW-1:0]        snp_line_i,
  input  logic                 rsp_valid_i,
  input  logic [LW-1:0]        rsp_line_i,
  input  logic [CW-1:0]        rsp_tokens_i,
  input  logic                 rsp_owner_i,
  input  logic                 rsp_data_i,
  output logic                 out_valid_o,
  output logic [LW-1:0]        out_line_o,
  output logic [CW-1:0]        out_tokens_o,
  output logic                 out_owner_o,
  output logic                 out_data_o,
  output logic                 out_to_mem_o,
  input  logic                 evict_i,
  input  logic [LW-1:0]        evict_line_i,
  output logic [NUM_LINES-1:0] escalate_o,
  output logic                 proto_err_o
);
  logic [NUM_LINES-1:0]         issue_v, kind_v, ovf_v, oown_v, odat_v, ov_v, grant_v;
  logic [NUM_LINES-1:0][CW-1:0] otok_v, line_tok;
  logic                         evict_go;

  // network requests take the single response port first
  assign evict_go = evict_i && !snp_valid_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tc_line #(
      .TOK_TOTAL(TOK_TOTAL),
      .AVG_LAT  (AVG_LAT),
      .LONG_MULT(LONG_MULT)
    ) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (cpu_req_i && (cpu_line_i == LW'(g))),
      .req_wr_i (cpu_wr_i),
      .snp_i    (snp_valid_i && (snp_line_i == LW'(g))),
      .snp_wr_i (snp_wr_i),
      .evict_i  (evict_go && (evict_line_i == LW'(g))),
      .rin_i    (rsp_valid_i && (rsp_line_i == LW'(g))),
      .rin_tok_i(rsp_tokens_i),
      .rin_own_i(rsp_owner_i),
      .rin_dat_i(rsp_data_i),
      .grant_i  (grant_v[g]),
      .out_tok_o(otok_v[g]),
      .out_own_o(oown_v[g]),
      .out_dat_o(odat_v[g]),
      .issue_o  (issue_v[g]),
      .kind_o   (kind_v[g]),
      .done_o   (cpu_done_o[g]),
      .pers_o   (escalate_o[g]),
      .ovf_o    (ovf_v[g]),
      .tok_o    (line_tok[g])
    );
    assign ov_v[g] = otok_v[g] != '0;
  end

  tc_pick #(.N(NUM_LINES)) u_bc_pick (
    .req_i(issue_v),
    .any_o(bcast_valid_o),
    .idx_o(bcast_line_o)
  );

  assign grant_v    = bcast_valid_o ? (NUM_LINES'(1) << bcast_line_o) : '0;
  assign bcast_wr_o = kind_v[bcast_line_o];

  tc_pick #(.N(NUM_LINES)) u_out_pick (
    .req_i(ov_v),
    .any_o(out_valid_o),
    .idx_o(out_line_o)
  );

  always_comb begin
    out_tokens_o = '0;
    out_owner_o  = 1'b0;
    out_data_o   = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      out_tokens_o = out_tokens_o | otok_v[i];
      out_owner_o  = out_owner_o | oown_v[i];
      out_data_o   = out_data_o | odat_v[i];
    end
  end

  assign out_to_mem_o = out_valid_o && !snp_valid_i;
  assign proto_err_o  = |ovf_v;
endmodule

// File: rtl/tc_ctrl_chk.sv
module tc_ctrl_chk #(
  parameter  int unsigned NL        = 4,
  parameter  int unsigned TOK_TOTAL = 16,
  localparam int unsigned LW        = (NL > 1) ? $clog2(NL) : 1,
  localparam int unsigned CW        = $clog2(TOK_TOTAL + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NL-1:0]         cpu_done_o,
  input logic [NL-1:0]         escalate_o,
  input logic                  snp_valid_i,
  input logic                  snp_wr_i,
  input logic [LW-1:0]         snp_line_i,
  input logic                  rsp_valid_i,
  input logic                  out_valid_o,
  input logic [CW-1:0]         out_tokens_o,
  input logic                  out_to_mem_o,
  input logic                  proto_err_o,
  input logic [NL-1:0][CW-1:0] line_tok
);
  for (genvar g = 0; g < NL; g++) begin : g_chk
    p_tok_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_tok[g] <= CW'(TOK_TOTAL));
    p_done_tokens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_done_o[g] |-> line_tok[g] != '0);
    p_esc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      escalate_o[g] && !cpu_done_o[g] |=> escalate_o[g]);
  end

  p_rd_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && !snp_wr_i && out_valid_o |-> out_tokens_o == CW'(1));
  p_evict_yield_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !out_to_mem_o);
  p_err_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> rsp_valid_i);
  p_wr_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_wr_i && !rsp_valid_i |=> line_tok[$past(snp_line_i)] == '0);
endmodule

bind tc_ctrl tc_ctrl_chk #(.NL(NUM_LINES), .TOK_TOTAL(TOK_TOTAL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_done_o  (cpu_done_o),
  .escalate_o  (escalate_o),
  .snp_valid_i (snp_valid_i),
  .snp_wr_i    (snp_wr_i),
  .snp_line_i  (snp_line_i),
  .rsp_valid_i (rsp_valid_i),
  .out_valid_o (out_valid_o),
  .out_tokens_o(out_tokens_o),
  .out_to_mem_o(out_to_mem_o),
  .proto_err_o (proto_err_o),
  .line_tok    (line_tok)
);

// File: tb/tc_ctrl_bench.sv
`timescale 1ns/1ps
module tc_ctrl_bench;
  localparam int NL = 4, T = 16, AVG = 4, LM = 4, LW = 2, CW = 5;
  localparam int TO = 2 * AVG, LONG = LM * TO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req, cpu_wr, snp_valid, snp_wr, rsp_valid, rsp_owner, rsp_data, evict;
  logic [LW-1:0] cpu_line, snp_line, rsp_line, evict_line, bcast_line, out_line;
  logic [CW-1:0] rsp_tokens, out_tokens;
  logic [NL-1:0] cpu_done, escalate;
  logic bcast_valid, bcast_wr, out_valid, out_owner, out_data, out_to_mem, proto_err;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tc_ctrl #(.NUM_LINES(NL), .TOK_TOTAL(T), .AVG_LAT(AVG), .LONG_MULT(LM)) u_tc_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_wr_i(cpu_wr), .cpu_line_i(cpu_line), .cpu_done_o(cpu_done),
    .bcast_valid_o(bcast_valid), .bcast_wr_o(bcast_wr), .bcast_line_o(bcast_line),
    .snp_valid_i(snp_valid), .snp_wr_i(snp_wr), .snp_line_i(snp_line),
    .rsp_valid_i(rsp_valid), .rsp_line_i(rsp_line), .rsp_tokens_i(rsp_tokens),
    .rsp_owner_i(rsp_owner), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_line_o(out_line), .out_tokens_o(out_tokens),
    .out_owner_o(out_owner), .out_data_o(out_data), .out_to_mem_o(out_to_mem),
    .evict_i(evict), .evict_line_i(evict_line),
    .escalate_o(escalate), .proto_err_o(proto_err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_req = 0; cpu_wr = 0; cpu_line = 0; snp_valid = 0; snp_wr = 0; snp_line = 0;
    rsp_valid = 0; rsp_line = 0; rsp_tokens = 0; rsp_owner = 0; rsp_data = 0;
    evict = 0; evict_line = 0;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic give(int ln, int tk, bit own, bit dat);
    rsp_valid = 1; rsp_line = LW'(ln); rsp_tokens = CW'(tk); rsp_owner = own; rsp_data = dat;
    step();
    rsp_valid = 0;
  endtask

  task automatic access(int ln, bit wr);
    cpu_req = 1; cpu_wr = wr; cpu_line = LW'(ln);
    step();
    cpu_req = 0;
  endtask

  task automatic t_reset();
    check("R1 done", int'(cpu_done), 0);
    check("R1 bcast", int'(bcast_valid), 0);
    check("R1 out", int'(out_valid), 0);
    check("R1 esc", int'(escalate), 0);
    check("R1 err", int'(proto_err), 0);
  endtask

  task automatic t_read_miss();
    access(0, 0);
    check("R8 bcast", int'(bcast_valid), 1);
    check("R8 line", int'(bcast_line), 0);
    check("R8 kind", int'(bcast_wr), 0);
    check("R2 not yet", int'(cpu_done[0]), 0);
    step();
    check("R8 single", int'(bcast_valid), 0);
    give(0, 16, 1, 1);
    check("R2 done", int'(cpu_done[0]), 1);
    step();
    check("R2 done pulse", int'(cpu_done[0]), 0);
  endtask

  task automatic t_hit();
    access(0, 0);
    check("R8 hit no bcast", int'(bcast_valid), 0);
    check("R2 hit done", int'(cpu_done[0]), 1);
    step();
  endtask

  task automatic t_rd_snoop();
    snp_valid = 1; snp_wr = 0; snp_line = 0;
    #1;
    check("R4 valid", int'(out_valid), 1);
    check("R4 tokens", int'(out_tokens), 1);
    check("R4 owner", int'(out_owner), 0);
    check("R4 data", int'(out_data), 1);
    check("R4 line", int'(out_line), 0);
    step();
    snp_valid = 0;
  endtask

  task automatic t_wr_pending();
    access(0, 1);
    check("R8 wr bcast", int'(bcast_valid), 1);
    check("R8 wr kind", int'(bcast_wr), 1);
    repeat (4) step();
    check("R3 pending 15", int'(cpu_done[0]), 0);
    give(0, 1, 0, 0);
    check("R3 done 16", int'(cpu_done[0]), 1);
    step();
  endtask

  task automatic t_wr_snoop();
    snp_valid = 1; snp_wr = 1; snp_line = 0;
    #1;
    check("R6 tokens", int'(out_tokens), 16);
    check("R6 owner", int'(out_owner), 1);
    check("R6 data", int'(out_data), 1);
    step();
    snp_valid = 0;
    access(0, 0);
    check("R6 drained, miss", int'(bcast_valid), 1);
    give(0, 16, 1, 1);
    check("R6 refill done", int'(cpu_done[0]), 1);
    step();
  endtask

  task automatic t_non_owner();
    give(1, 3, 0, 1);
    snp_valid = 1; snp_wr = 0; snp_line = 1;
    #1;
    check("R5 no rsp", int'(out_valid), 0);
    step();
    snp_wr = 1;
    #1;
    check("R5 count kept", int'(out_tokens), 3);
    check("R6 no owner", int'(out_owner), 0);
    check("R6 data", int'(out_data), 1);
    check("R6 line", int'(out_line), 1);
    step();
    snp_valid = 0;
  endtask

  task automatic t_overflow();
    give(2, 10, 0, 0);
    rsp_valid = 1; rsp_line = 2; rsp_tokens = 7; rsp_owner = 0; rsp_data = 0;
    #1;
    check("R7 err", int'(proto_err), 1);
    step();
    rsp_valid = 0;
    #1;
    check("R7 err clear", int'(proto_err), 0);
    snp_valid = 1; snp_wr = 1; snp_line = 2;
    #1;
    check("R7 discarded", int'(out_tokens), 10);
    step();
    snp_valid = 0;
  endtask

  task automatic t_evict();
    give(3, 5, 1, 1);
    evict = 1; evict_line = 3; snp_valid = 1; snp_wr = 0; snp_line = 1;
    #1;
    check("R11 yield", int'(out_valid), 0);
    step();
    snp_valid = 0;
    #1;
    check("R11 tokens", int'(out_tokens), 5);
    check("R11 owner", int'(out_owner), 1);
    check("R11 data", int'(out_data), 1);
    check("R11 to mem", int'(out_to_mem), 1);
    check("R11 line", int'(out_line), 3);
    step();
    evict = 0;
    snp_valid = 1; snp_wr = 1; snp_line = 3;
    #1;
    check("R11 empty", int'(out_valid), 0);
    step();
    snp_valid = 0;
    access(3, 0);
    give(3, 2, 0, 0);
    evict = 1; evict_line = 3;
    #1;
    check("R11 miss blocks", int'(out_valid), 0);
    step();
    evict = 0;
    give(3, 0, 0, 1);
    check("R2 data late", int'(cpu_done[3]), 1);
    step();
    snp_valid = 1; snp_wr = 1; snp_line = 3;
    #1;
    check("R11 kept 2", int'(out_tokens), 2);
    step();
    snp_valid = 0;
  endtask

  task automatic starve(output int nb, output int esc_gap);
    int last;
    access(2, 1);
    nb = bcast_valid ? 1 : 0;
    last = 0;
    esc_gap = -1;
    for (int k = 1; k < 300; k++) begin
      step();
      if (bcast_valid && bcast_line == 2) begin
        nb++;
        check("R9 gap", k - last, TO + 1);
        last = k;
      end
      if (escalate[2]) begin
        esc_gap = k - last;
        break;
      end
    end
  endtask

  task automatic t_timeout();
    int nb, gap;
    starve(nb, gap);
    check("R10 attempts", nb, 4);
    check("R10 wait", gap, TO + 1 + LONG);
    give(2, 16, 1, 1);
    check("R10 done", int'(cpu_done[2]), 1);
    step();
    check("R10 esc clear", int'(escalate[2]), 0);
    snp_valid = 1; snp_wr = 1; snp_line = 2;
    step();
    snp_valid = 0;
    starve(nb, gap);
    check("R10 fresh attempts", nb, 4);
    give(2, 16, 1, 1);
    step();
  endtask

  initial begin
    idle();
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_read_miss();
    t_hit();
    t_rd_snoop();
    t_wr_pending();
    t_wr_snoop();
    t_non_owner();
    t_overflow();
    t_evict();
    t_timeout();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule